// File: doc/BRIEF.md
# Seven-Slot Double-Data-Rate Word Aligner

This block turns a serial double-data-rate bit stream into aligned words of seven bits. The fast clock runs at 3.5 times a slower reference clock, so each slow period carries seven data slots: two per fast cycle, one on each edge. The block does not hunt for a training pattern to find the word boundary. Instead, a toggle signal from the slow domain is sampled on both fast-clock edges. A change between two neighbouring samples marks the half-period where a new word begins. Because seven halves is an odd count, the boundary falls on a rising edge in one slow period and on a falling edge in the next, so the two marker outputs fire in turn.

Each data bit and each toggle sample goes into a short history register that shifts by two positions every fast cycle. When a marker fires, the seven data halves before the marked half are taken as one word. A tracker measures the distance between markers in half-periods. Words are released only while that distance is exactly seven. Any other spacing raises a sticky misalignment flag and restarts alignment.

Top module: `ddr7_aligner`

## Requirements
- R1: While reset is high and right after it, `word` is 0 and `word_vld`, `mark_rise`, `mark_fall` and `misalign` are low. Reset also clears a set `misalign`.
- R2: `ddr_bit` and `frame_tog` are sampled on both clock edges. A toggle change between a rising-edge sample and the next falling-edge sample raises `mark_fall`. A change between a falling-edge sample and the next rising-edge sample raises `mark_rise`. Either marker is visible for the one cycle after the rising edge that completes the comparison.
- R3: The word carries the seven data halves that start at the half where the previous toggle change was seen. The oldest half (slot 0) is in bit 6 and the newest in bit 0. `word` holds its value between strobes.
- R4: `word_vld` is a single-cycle pulse. It rises in the cycle after the marker that closes the word.
- R5: With a steady toggle every seven halves, the strobes are spaced alternately 3 and 4 cycles apart, and the two markers fire in turn.
- R6: After reset, the first marker only arms the block and produces no word. A word comes out only at a marker that lies exactly seven halves after the previous one.
- R7: A marker at a spacing other than seven halves from an armed reference produces no word and sets `misalign`. The flag stays set until reset. That marker becomes the new reference.
- R8: If both markers fire in the same cycle, no word is produced, `misalign` is set, and the block disarms. The next marker is only a reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; both edges sample inputs |
| rst | input | 1 | Asynchronous reset, active high |
| ddr_bit | input | 1 | Serial data, one slot per clock edge |
| frame_tog | input | 1 | Slow-domain toggle, flips once per word |
| word | output | 7 | Last aligned word, slot 0 in the MSB |
| word_vld | output | 1 | One-cycle strobe for a new word |
| mark_rise | output | 1 | Boundary found at a rising-edge sample |
| mark_fall | output | 1 | Boundary found at a falling-edge sample |
| misalign | output | 1 | Sticky flag for bad marker spacing |

## Verification
The hardest situation to reach is two markers in one cycle. To get it, the toggle must flip at a falling-edge sample and flip back at the very next rising-edge sample. The bench drives inputs on a half-period schedule in which it knows the edge each stream index lands on, so it can place that glitch exactly. Gaps of eight and six halves are built the same way by stretching or shortening one word. The bench then confirms which words survive each fault.

// File: rtl/ddr7_pkg.sv
package ddr7_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } mark_t;

  // Distance between two markers in half-periods.
  // cyc: full cycles between the marker cycles.
  // pf/cf: the previous/current marker was a falling-edge one.
  function automatic logic [7:0] half_gap(input logic [7:0] cyc,
                                          input logic pf,
                                          input logic cf);
    return (cyc << 1) + {7'd0, pf} - {7'd0, cf};
  endfunction

endpackage

// File: rtl/ddr7_edge_sampler.sv
module ddr7_edge_sampler #(
  parameter int DEPTH = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_bit,
  output logic [DEPTH-1:0] hist
);
  logic neg_q;

  always_ff @(negedge clk or posedge rst) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= in_bit;
  end

  // Bit 0 is the newest rising-edge sample; bit 1 is the falling-edge sample before it.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) hist <= '0;
    else     hist <= {hist[DEPTH-3:0], neg_q, in_bit};
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    hist[DEPTH-1:2] == $past(hist[DEPTH-3:0])) else $error("history shift broken"); // R2

endmodule

// File: rtl/ddr7_marker.sv
module ddr7_marker
  import ddr7_pkg::*;
(
  input  logic [2:0] tog_hist,
  output mark_t      mk
);
  always_comb begin
    mk.rise = tog_hist[0] ^ tog_hist[1];
    mk.fall = tog_hist[1] ^ tog_hist[2];
  end
endmodule

// File: rtl/ddr7_frame_tracker.sv
module ddr7_frame_tracker
  import ddr7_pkg::*;
#(
  parameter int SLOTS = 7
) (
  input  logic  clk,
  input  logic  rst,
  input  mark_t mk,
  output logic  emit,
  output logic  armed,
  output logic  misalign
);
  localparam int CW = $clog2(SLOTS + 1);
  localparam logic [CW-1:0] CMAX = CW'(SLOTS);

  logic [CW-1:0] cyc;
  logic          prev_fall;
  logic          any_mark, both_mark, gap_ok, bad;
  logic [7:0]    gap;

  assign any_mark  = mk.rise | mk.fall;
  assign both_mark = mk.rise & mk.fall;
  assign gap       = half_gap(8'(cyc), prev_fall, mk.fall);
  assign gap_ok    = (gap == 8'(SLOTS));
  assign emit      = any_mark & ~both_mark & armed & gap_ok;
  assign bad       = (any_mark & armed & ~gap_ok) | both_mark;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cyc       <= '0;
      prev_fall <= 1'b0;
      armed     <= 1'b0;
      misalign  <= 1'b0;
    end else begin
      if (any_mark) begin
        cyc       <= CW'(1);
        prev_fall <= mk.fall;
        armed     <= ~both_mark;
      end else if (cyc != CMAX) begin
        cyc <= cyc + CW'(1);
      end
      if (bad) misalign <= 1'b1;
    end
  end

  AST_MIS_STICKY: assert property (@(posedge clk) disable iff (rst)
    misalign |=> misalign) else $error("misalign dropped"); // R7
  AST_DOUBLE_DISARM: assert property (@(posedge clk) disable iff (rst)
    (mk.rise && mk.fall) |=> (!armed && misalign)) else $error("double marker kept arm"); // R8

endmodule

// File: rtl/ddr7_aligner.sv
module ddr7_aligner
  import ddr7_pkg::*;
#(
  parameter int SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ddr_bit,
  input  logic             frame_tog,
  output logic [SLOTS-1:0] word,
  output logic             word_vld,
  output logic             mark_rise,
  output logic             mark_fall,
  output logic             misalign
);
  localparam int DDEPTH = SLOTS + 2;

  logic [DDEPTH-1:0] data_hist;
  logic [2:0]        tog_hist;
  mark_t             mk;
  logic              emit_now, trk_armed;
  logic [SLOTS-1:0]  pick;

  ddr7_edge_sampler #(.DEPTH(DDEPTH)) u_data (
    .clk(clk), .rst(rst), .in_bit(ddr_bit), .hist(data_hist));

  ddr7_edge_sampler #(.DEPTH(3)) u_tog (
    .clk(clk), .rst(rst), .in_bit(frame_tog), .hist(tog_hist));

  ddr7_marker u_mark (.tog_hist(tog_hist), .mk(mk));

  ddr7_frame_tracker #(.SLOTS(SLOTS)) u_trk (
    .clk(clk), .rst(rst), .mk(mk), .emit(emit_now),
    .armed(trk_armed), .misalign(misalign));

  // A falling-edge boundary sits one half further back in the history.
  assign pick = mk.fall ? data_hist[SLOTS+1:2] : data_hist[SLOTS:1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= emit_now;
      if (emit_now) word <= pick;
    end
  end

  assign mark_rise = mk.rise;
  assign mark_fall = mk.fall;

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> !word_vld) else $error("strobe longer than one cycle"); // R4
  AST_VLD_AFTER_MARK: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(mark_rise || mark_fall)) else $error("strobe without marker"); // R4
  AST_VLD_ARMED: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(trk_armed)) else $error("word from unarmed tracker"); // R6
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word)) else $error("word moved without strobe"); // R3

endmodule

// File: tb/tb_ddr7_aligner.sv
`timescale 1ns/1ps
module tb_ddr7_aligner;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ddr_bit = 1'b0;
  logic frame_tog = 1'b0;
  logic [6:0] word;
  logic word_vld, mark_rise, mark_fall, misalign;

  ddr7_aligner dut (.clk(clk), .rst(rst), .ddr_bit(ddr_bit), .frame_tog(frame_tog),
                    .word(word), .word_vld(word_vld), .mark_rise(mark_rise),
                    .mark_fall(mark_fall), .misalign(misalign));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic sd [0:511];
  logic st [0:511];
  int   sp;
  logic curt;

  logic [6:0] got [0:63];
  int   gcyc [0:63];
  int   ng, nr, nf, cyc, dbl;
  logic prev_vld;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (word_vld && ng < 64) begin got[ng] = word; gcyc[ng] = cyc; ng++; end
      if (word_vld && prev_vld) dbl++;
      if (mark_rise) nr++;
      if (mark_fall) nf++;
      prev_vld = word_vld;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ddr_bit = 1'b0; frame_tog = 1'b0;
    curt = 1'b0; sp = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(word == 7'd0 && !word_vld && !mark_rise && !mark_fall && !misalign, "R1",
        {word_vld, mark_rise, mark_fall, misalign}, 0);
    @(posedge clk); #2;
    rst = 1'b0;
    ng = 0; nr = 0; nf = 0; cyc = 0; dbl = 0; prev_vld = 1'b0;
  endtask

  task automatic add_word(input logic [6:0] w, input int len);
    for (int i = 0; i < len; i++) begin
      if (i == 0) curt = ~curt;
      sd[sp] = (i < 7) ? w[6-i] : 1'b0;
      st[sp] = curt;
      sp++;
    end
  endtask

  task automatic pad(input int n);
    for (int i = 0; i < n; i++) begin sd[sp] = 1'b0; st[sp] = curt; sp++; end
  endtask

  // Index 0 is sampled by a falling edge, index 1 by the next rising edge, and so on.
  task automatic play();
    @(posedge clk);
    for (int k = 0; k < sp; k++) begin
      #2; ddr_bit = sd[k]; frame_tog = st[k];
      @(posedge clk or negedge clk);
    end
    #2; ddr_bit = 1'b0;
    repeat (8) @(posedge clk);
    #2;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk(!word_vld && !misalign && word == 7'd0, "R1", word, 0);
    chk(!mark_rise && !mark_fall, "R1", {mark_rise, mark_fall}, 0);
  endtask

  task automatic t_steady();
    logic [6:0] w [0:5];
    w[0] = 7'h2A; w[1] = 7'h55; w[2] = 7'h7F; w[3] = 7'h00; w[4] = 7'h13; w[5] = 7'h6C;
    do_reset();
    pad(3);
    for (int i = 0; i < 6; i++) add_word(w[i], 7);
    add_word(7'h41, 7);
    pad(10);
    play();
    chk(ng == 6, "R3", ng, 6);
    for (int i = 0; i < 6; i++) chk(got[i] == w[i], "R3", got[i], w[i]);
    chk(nr + nf == 7, "R2", nr + nf, 7);
    chk(nr >= 3 && nf >= 3, "R5", nr * 10 + nf, 43);
    for (int i = 1; i < 6; i++) begin
      int d = gcyc[i] - gcyc[i-1];
      chk(d == 3 || d == 4, "R5", d, 4);
      if (i > 1) chk(d != gcyc[i-1] - gcyc[i-2], "R5", d, 7 - d);
    end
    chk(dbl == 0, "R4", dbl, 0);
    chk(!misalign, "R7", misalign, 0);
  endtask

  task automatic t_single_marker();
    do_reset();
    pad(2);
    add_word(7'h15, 7);
    pad(30);
    play();
    chk(nr + nf == 1, "R6", nr + nf, 1);
    chk(ng == 0, "R6", ng, 0);
    chk(!misalign, "R6", misalign, 0);
  endtask

  task automatic t_bad_gap();
    logic [6:0] w [0:5];
    int lens [0:5];
    w[0] = 7'h11; w[1] = 7'h22; w[2] = 7'h33; w[3] = 7'h44; w[4] = 7'h5B; w[5] = 7'h66;
    lens[0] = 7; lens[1] = 7; lens[2] = 8; lens[3] = 6; lens[4] = 7; lens[5] = 7;
    do_reset();
    pad(2);
    for (int i = 0; i < 6; i++) add_word(w[i], lens[i]);
    add_word(7'h00, 7);
    pad(10);
    play();
    chk(ng == 4, "R7", ng, 4);
    chk(got[0] == w[0] && got[1] == w[1], "R7", got[1], w[1]);
    chk(got[2] == w[4], "R7", got[2], w[4]);
    chk(got[3] == w[5], "R7", got[3], w[5]);
    chk(misalign, "R7", misalign, 1);
    repeat (5) @(posedge clk);
    #2;
    chk(misalign, "R7", misalign, 1);
    do_reset();
    #1;
    chk(!misalign, "R1", misalign, 0);
  endtask

  task automatic t_double_marker();
    do_reset();
    pad(2);
    add_word(7'h4D, 7);
    add_word(7'h1E, 7);
    add_word(7'h7F, 1);
    add_word(7'h2C, 7);
    add_word(7'h39, 7);
    add_word(7'h62, 7);
    add_word(7'h00, 7);
    pad(10);
    play();
    chk(ng == 3, "R8", ng, 3);
    chk(got[0] == 7'h4D, "R8", got[0], 7'h4D);
    chk(got[1] == 7'h39, "R8", got[1], 7'h39);
    chk(got[2] == 7'h62, "R8", got[2], 7'h62);
    chk(misalign, "R8", misalign, 1);
  endtask

  initial begin
    t_reset_state();
    t_steady();
    t_single_marker();
    t_bad_gap();
    t_double_marker();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule